// File: doc/BRIEF.md
# Byte ALU with Decimal Correction

This block is the arithmetic and logic unit of a small accumulator machine. Each cycle in which `issue` is high, it takes an accumulator byte, an operand byte, the current status byte and a four-bit operation code. One clock later it presents the result byte, the new status byte and a strobe that says whether the result should be written back. Decoding instructions, fetching operands and holding the register file all belong to the surrounding core.

Addition and subtraction work in plain binary or in packed BCD, depending on the decimal bit of the incoming status. In BCD mode the binary sum is repaired by one correction term. That term comes from the half-carry and carry positions, which are recovered by XOR. The block does not compare each nibble and add six to it. Logic operations, a load pass-through, a bit test, an unsigned compare and four single-bit shift and rotate forms are also supported. The shifts and rotates act on the operand byte, so the core routes either the accumulator or a memory byte through that input.

Top module: `byte_alu`

## Requirements
- R1: Status layout: carry bit 0, zero bit 1, interrupt-disable bit 2, decimal bit 3, break bit 4, spare bit 5, overflow bit 6, sign bit 7. Bits 5:2 of the output status always equal the incoming status bits for the issued operation.
- R2: Op 0 (add), decimal bit clear:
  - the result is the low byte of A + operand + carry-in;
  - carry is bit 8 of that sum;
  - overflow is bit 7 of (sum XOR A) AND (sum XOR operand);
  - zero and sign come from the result byte.
- R3: Op 0, decimal bit set: the 16-bit sum s is corrected to s + 3*((((s + 0x66) XOR A XOR operand) >> 3) AND 0x22). Carry is set when any of bits 15:8 of the corrected value is 1. Overflow, zero and sign are taken from the uncorrected sum.
- R4: Op 1 (subtract) inverts the operand. When the decimal bit is set it also subtracts 0x66 from the inverted operand, modulo 2^16. It then follows the same sum, overflow, correction and flag rules as R2/R3, and the modified operand takes the place of the operand in those rules.
- R5: Ops 2 (AND), 3 (OR), 4 (XOR) and 11 (load operand) write their result. Only zero and sign change; carry and overflow pass through.
- R6: Op 5 (bit test): zero is set when A AND operand is 0, sign takes operand bit 7 and overflow takes operand bit 6. Carry is unchanged and no write strobe is raised.
- R7: Op 6 (compare): carry is set when A >= operand (unsigned). Zero and sign come from the byte A - operand. Overflow is unchanged and no write strobe is raised.
- R8: Ops 7 to 10 act on the operand and update zero and sign from the result. Their carry and result are:
  - op 7 shifts left, filling bit 0 with 0; carry takes old bit 7;
  - op 8 shifts right, filling bit 7 with 0; carry takes old bit 0;
  - op 9 rotates left; the old carry enters bit 0 and old bit 7 goes to carry;
  - op 10 rotates right; the old carry enters bit 7 and old bit 0 goes to carry.
- R9: Outputs are registered. The cycle after an issue, `done` is high and `res_wr` is high for the writing ops (0 to 4 and 7 to 11).
- R10: A cycle without issue leaves the result and status held, with `res_wr` and `done` low. Reserved ops 12 to 15 give `done` but no write; the status equals the incoming status and the result equals the accumulator.
- R11: A synchronous reset clears the result, status, `res_wr` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation request this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator or register byte |
| opnd_in | input | 8 | Operand byte |
| stat_in | input | 8 | Incoming status byte |
| res_q | output | 8 | Registered result byte |
| stat_q | output | 8 | Registered status byte |
| res_wr | output | 1 | Result should be written back |
| done | output | 1 | An operation completed last cycle |

## Verification
The bench builds the block with its default width of 8. At that width, 0x66 is the decimal offset and 0x22 is the correction mask. Random operands, with both carry-in values and both decimal settings, drive every op code. This reaches the 16-bit wrap of the decimal subtract offset for operands above 0x99. Directed cases cover the BCD carry from 99 to 00, a borrow out of 00, and reserved codes mixed with idle cycles.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_BIT  = 4'd5,
    OP_CMP  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_LOAD = 4'd11
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_D = 3;
  localparam int FL_V = 6;
  localparam int FL_N = 7;
endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         dec,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out,
  output logic         z_out,
  output logic         n_out
);
  localparam int DW  = 2 * W;
  localparam int NIB = W / 4;
  localparam logic [W-1:0] SIX  = {NIB{4'h6}};
  localparam logic [W-1:0] MASK = {NIB{4'h2}};

  logic [DW-1:0] bx, sum, tweak, fix, fin;

  always_comb begin
    bx = {{W{1'b0}}, (sub ? ~b : b)};
    if (sub && dec) bx = bx - {{W{1'b0}}, SIX};
    sum   = {{W{1'b0}}, a} + bx + {{(DW-1){1'b0}}, cin};
    tweak = ((sum + {{W{1'b0}}, SIX}) ^ {{W{1'b0}}, a} ^ bx) >> 3;
    fix   = tweak & {{W{1'b0}}, MASK};
    fin   = dec ? (sum + fix + (fix << 1)) : sum;
  end

  assign v_out = (sum[W-1] ^ a[W-1]) & (sum[W-1] ^ bx[W-1]);
  assign z_out = (sum[W-1:0] == '0);
  assign n_out = sum[W-1];
  assign c_out = |fin[DW-1:W];
  assign res   = fin[W-1:0];
endmodule

// File: rtl/byte_alu_misc.sv
module byte_alu_misc
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         vin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out,
  output logic         z_out,
  output logic         n_out
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    res   = a;
    c_out = cin;
    v_out = vin;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_LOAD: res = b;
      OP_SHL:  begin res = {b[W-2:0], 1'b0}; c_out = b[W-1]; end
      OP_SHR:  begin res = {1'b0, b[W-1:1]}; c_out = b[0];   end
      OP_ROL:  begin res = {b[W-2:0], cin};  c_out = b[W-1]; end
      OP_ROR:  begin res = {cin, b[W-1:1]};  c_out = b[0];   end
      OP_CMP:  c_out = (a >= b);
      default: res = a;
    endcase
    z_out = (res == '0);
    n_out = res[W-1];
    if (op == OP_BIT) begin
      z_out = ((a & b) == '0);
      n_out = b[W-1];
      v_out = b[W-2];
    end else if (op == OP_CMP) begin
      z_out = (diff == '0);
      n_out = diff[W-1];
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [W-1:0] stat_in,
  output logic [W-1:0] res_q,
  output logic [W-1:0] stat_q,
  output logic         res_wr,
  output logic         done
);
  localparam logic [3:0] LAST_OP = 4'(OP_LOAD);

  alu_op_e      op;
  logic         is_arith, is_rsv, is_logic, is_test, writes;
  logic [W-1:0] as_res, m_res, nres, nstat;
  logic         as_c, as_v, as_z, as_n, m_c, m_v, m_z, m_n;

  assign op       = alu_op_e'(op_sel);
  assign is_rsv   = (op_sel > LAST_OP);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_LOAD);
  assign is_test  = (op == OP_BIT) || (op == OP_CMP);
  assign writes   = !is_rsv && !is_test;

  byte_alu_addsub #(.W(W)) u_addsub (
    .a(acc_in), .b(opnd_in), .cin(stat_in[FL_C]), .dec(stat_in[FL_D]),
    .sub(op == OP_SUB), .res(as_res), .c_out(as_c), .v_out(as_v),
    .z_out(as_z), .n_out(as_n)
  );

  byte_alu_misc #(.W(W)) u_misc (
    .op(op), .a(acc_in), .b(opnd_in), .cin(stat_in[FL_C]), .vin(stat_in[FL_V]),
    .res(m_res), .c_out(m_c), .v_out(m_v), .z_out(m_z), .n_out(m_n)
  );

  always_comb begin
    nstat = stat_in;
    nres  = acc_in;
    if (!is_rsv) begin
      nres        = is_arith ? as_res : m_res;
      nstat[FL_C] = is_arith ? as_c : m_c;
      nstat[FL_Z] = is_arith ? as_z : m_z;
      nstat[FL_V] = is_arith ? as_v : m_v;
      nstat[FL_N] = is_arith ? as_n : m_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      stat_q <= '0;
      res_wr <= 1'b0;
      done   <= 1'b0;
    end else begin
      done   <= issue;
      res_wr <= issue && writes;
      if (issue) begin
        res_q  <= nres;
        stat_q <= nstat;
      end
    end
  end

  // R9: a write strobe only accompanies a completed operation
  a_r9_wr_with_done: assert property (@(posedge clk) disable iff (rst)
    res_wr |-> done);

  // R1: control bits travel through untouched
  a_r1_ctrl_bits_pass: assert property (@(posedge clk) disable iff (rst)
    done |-> stat_q[5:2] == $past(stat_in[5:2]));

  // R5: logic and load leave carry and overflow alone
  a_r5_logic_keeps_cv: assert property (@(posedge clk) disable iff (rst)
    done && $past(is_logic) |->
      stat_q[FL_C] == $past(stat_in[FL_C]) && stat_q[FL_V] == $past(stat_in[FL_V]));

  // R6, R7: test operations never request a write
  a_r6_test_no_write: assert property (@(posedge clk) disable iff (rst)
    done && $past(is_test) |-> !res_wr);

  // R10: idle cycles hold the outputs
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(res_q) && $stable(stat_q) && !res_wr);
endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, stat_in = '0;
  logic [7:0] res_q, stat_q;
  logic       res_wr, done;

  int checks = 0, failures = 0;
  logic [7:0] e_res = '0, e_stat = '0;
  logic       e_wr = 1'b0, e_done = 1'b0;
  string      e_tag = "R11 reset";
  bit         finished = 0;

  always #4 clk = ~clk;

  byte_alu u0 (
    .clk(clk), .rst(rst), .issue(issue), .op_sel(op_sel), .acc_in(acc_in),
    .opnd_in(opnd_in), .stat_in(stat_in), .res_q(res_q), .stat_q(stat_q),
    .res_wr(res_wr), .done(done)
  );

  task automatic model(input int op, input int a, input int b, input int s,
                       output logic [7:0] r, output logic [7:0] st, output logic w);
    int c, d, bv, sum, t;
    c = s & 1; d = (s >> 3) & 1; st = s[7:0]; r = a[7:0]; w = 1;
    if (op <= 1) begin
      bv = b;
      if (op == 1) begin
        bv = (~b) & 255;
        if (d == 1) bv = (bv - 'h66) & 'hFFFF;
      end
      sum = (a + bv + c) & 'hFFFF;
      st[6] = (((sum ^ a) & (sum ^ bv) & 'h80) != 0);
      st[1] = ((sum & 255) == 0);
      st[7] = sum[7];
      if (d == 1) begin
        t = ((((sum + 'h66) & 'hFFFF) ^ a ^ bv) >> 3) & 'h22;
        sum = (sum + 3 * t) & 'hFFFF;
      end
      st[0] = ((sum & 'hFF00) != 0);
      r = sum[7:0];
    end else if (op >= 12) begin
      w = 0;
    end else begin
      case (op)
        2: r = a[7:0] & b[7:0];
        3: r = a[7:0] | b[7:0];
        4: r = a[7:0] ^ b[7:0];
        11: r = b[7:0];
        7: begin r = 8'((b * 2) & 255); st[0] = b[7]; end
        8: begin r = 8'(b / 2); st[0] = b[0]; end
        9: begin r = 8'(((b * 2) + c) & 255); st[0] = b[7]; end
        10: begin r = 8'((b / 2) + c * 128); st[0] = b[0]; end
        default: r = a[7:0];
      endcase
      st[1] = (r == 0); st[7] = r[7];
      if (op == 5) begin
        w = 0; st[1] = ((a & b) == 0); st[7] = b[7]; st[6] = b[6];
      end else if (op == 6) begin
        w = 0; t = (a - b) & 255;
        st[0] = (a >= b); st[1] = (t == 0); st[7] = t[7];
      end
    end
  endtask

  function automatic string tag_of(int op, int s);
    if (op == 0) return (s[3] ? "R3 R1/R9 dec add" : "R2 R1/R9 bin add");
    if (op == 1) return "R4 R1/R9 subtract";
    if (op == 2 || op == 3 || op == 4 || op == 11) return "R5 R1/R9 logic";
    if (op == 5) return "R6 R1/R9 bit test";
    if (op == 6) return "R7 R1/R9 compare";
    if (op >= 7 && op <= 10) return "R8 R1/R9 shift";
    return "R10 reserved";
  endfunction

  task automatic compare_now();
    checks++;
    if (res_q !== e_res || stat_q !== e_stat || res_wr !== e_wr || done !== e_done) begin
      failures++;
      $display("FAIL %s: res=%h stat=%h wr=%b done=%b expected res=%h stat=%h wr=%b done=%b",
               e_tag, res_q, stat_q, res_wr, done, e_res, e_stat, e_wr, e_done);
    end
  endtask

  task automatic step(input bit iss, input int op, input int a, input int b, input int s);
    logic [7:0] r, st;
    logic w;
    @(negedge clk);
    compare_now();
    issue = iss; op_sel = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; stat_in = s[7:0];
    if (iss) begin
      model(op, a, b, s, r, st, w);
      e_res = r; e_stat = st; e_wr = w; e_done = 1; e_tag = tag_of(op, s);
    end else begin
      e_wr = 0; e_done = 0; e_tag = "R10 idle hold";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_now();                       // R11 reset state
    rst = 1'b0;
    e_tag = "R10 idle after reset";
    step(1, 0, 'h09, 'h01, 'h08);        // R3 09+01 -> 10
    step(1, 0, 'h99, 'h01, 'h08);        // R3 99+01 -> 00 carry
    step(1, 1, 'h10, 'h01, 'h09);        // R4 10-01 -> 09
    step(1, 1, 'h00, 'h01, 'h09);        // R4 00-01 -> 99 borrow
    step(1, 0, 'h7F, 'h01, 'h00);        // R2 signed overflow
    step(1, 0, 'hFF, 'h00, 'h01);        // R2 carry, zero
    step(0, 0, 'h55, 'h55, 'hFF);        // R10 idle
    step(1, 13, 'h3C, 'h11, 'hA5);       // R10 reserved
    step(1, 5, 'h0F, 'hC0, 'h00);        // R6
    step(1, 6, 'h40, 'h40, 'h00);        // R7 equal
    step(1, 10, 'h00, 'h01, 'h01);       // R8 ror
    step(1, 9, 'h00, 'h80, 'h00);        // R8 rol
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, int'($urandom % 16), int'($urandom % 256),
           int'($urandom % 256), int'($urandom % 256));
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule